// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host read and write single 16-bit words in an asynchronous static RAM with 18 address bits. The host offers a request with a valid/ready handshake. The request carries an address, write data, a two-bit lane mask and a read/write flag. Read results come back with a one-cycle valid pulse.

On the memory side the controller drives the following pins from registers:
- the address;
- two chip selects, one active-low and one active-high;
- active-low write and output enables;
- active-low lower and upper byte selects;
- a data output with a separate output-enable, for a pad ring outside the block.

Each wait count is derived at elaboration as the ceiling of a nanosecond minimum divided by the clock period, with a floor of one cycle. The speed grade parameter picks the 55 ns or the 70 ns minimums. With the defaults (8 ns clock, fast grade) the counts are as follows:
- a read holds its strobes for 7 cycles;
- a write pulse lasts 7 cycles;
- the bus turnaround gap is 3 cycles;
- the wake delay after power-down is 7 cycles.

A power-down input parks the chip in its lowest-power deselect and refuses new work.

Top module: `asram_ctl`

## Requirements
- R1: After reset `ram_cs_n`, `ram_we_n`, `ram_oe_n`, `ram_lb_n` and `ram_ub_n` are 1, `ram_cs` is 1, `ram_dq_oe` is 0 and `req_ready` is 1.
- R2: An accepted read holds `ram_cs_n`=0, `ram_cs`=1, `ram_oe_n`=0 and `ram_we_n`=1 for exactly 7 cycles at the defaults. `rd_valid` is then high for one cycle, the cycle after the strobes drop.
- R3: Mask bit 0 enables the lower lane (bits 7:0, `ram_lb_n`) and bit 1 enables the upper lane (bits 15:8, `ram_ub_n`). A lane whose bit is 0 keeps its select at 1, and on a read its bits of `rd_data` are 0.
- R4: An accepted write drives `ram_we_n`=0 for exactly 7 cycles at the defaults, with `ram_oe_n`=1. `ram_dq_out` carries the host data from the first cycle. Only the lanes enabled in the mask are stored; mask 00 changes nothing.
- R5: `ram_we_n` rises one cycle before `ram_dq_oe` falls and before the chip select is released.
- R6: Address and lane selects stay unchanged while `ram_cs_n` is 0. `ram_cs_n` returns to 1 for at least one cycle between accesses.
- R7: `ram_dq_oe` is never 1 while `ram_oe_n` is 0. After `ram_oe_n` rises, `ram_dq_oe` stays 0 for more than 3 cycles (20 ns), so a write offered in that window is stalled while a read is not.
- R8: While `pwr_down` is 1 and no access is in flight, `ram_cs` is 0, `ram_cs_n` is 1 and `req_ready` is 0. An access already started completes first.
- R9: After `pwr_down` falls, `ram_cs` returns to 1 at the next edge and `req_ready` stays 0 for a further 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Request lowest-power deselect |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 lower, bit 1 upper |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data, disabled lanes zero |
| ram_addr | output | 18 | Memory address |
| ram_cs_n | output | 1 | Active-low chip select |
| ram_cs | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_lb_n | output | 1 | Lower byte select, active low |
| ram_ub_n | output | 1 | Upper byte select, active low |
| ram_dq_out | output | 16 | Data toward the memory |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |
| ram_dq_in | input | 16 | Data from the memory |

## Verification
Two situations put two of the block's functions into the same cycle.

The first is the end of a read's high-impedance window meeting a write request. The bench holds a write valid directly behind a read. The behavioural model then predicts, cycle by cycle, when `req_ready` rises, and a time check confirms that the drive enable stays off for 20 ns after output enable rises.

The second is power-down meeting a pending request. The bench raises `pwr_down` during a read while a write waits behind it. It then judges that the read finishes, the chip select drops, the write is refused throughout, and the write is only taken after the wake delay.

// File: rtl/asram_ctl.sv
module asram_ctl #(
  parameter int CLK_NS     = 8,
  parameter bit FAST_GRADE = 1,
  parameter int AW         = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_down,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs_n,
  output logic          ram_cs,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic          ram_lb_n,
  output logic          ram_ub_n,
  output logic [15:0]   ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [15:0]   ram_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_RC  = FAST_GRADE ? 55 : 70;
  localparam int T_AA  = FAST_GRADE ? 55 : 70;
  localparam int T_OE  = FAST_GRADE ? 35 : 40;
  localparam int T_WC  = FAST_GRADE ? 55 : 70;
  localparam int T_WP  = FAST_GRADE ? 40 : 50;
  localparam int T_AW  = FAST_GRADE ? 50 : 60;
  localparam int T_DW  = FAST_GRADE ? 25 : 30;
  localparam int T_HZ  = FAST_GRADE ? 20 : 25;

  localparam int N_RD  = cyc(mx(mx(T_RC, T_AA), T_OE));
  localparam int N_WP  = mx(cyc(mx(mx(T_WP, T_AW), T_DW)), cyc(T_WC) - 1);
  localparam int N_HZ  = cyc(T_HZ);
  localparam int N_RC  = cyc(T_RC);
  localparam int N_MAX = mx(mx(N_RD, N_WP), mx(N_HZ + 1, N_RC));
  localparam int CW    = $clog2(N_MAX + 2);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_WH} st_t;

  st_t           st;
  logic [CW-1:0] cnt, hz_cnt, wake_cnt;
  logic          pd_q;
  logic [15:0]   lane_bits;

  assign lane_bits = {{8{~ram_ub_n}}, {8{~ram_lb_n}}};

  assign req_ready = (st == S_IDLE) && !pwr_down && !pd_q &&
                     (wake_cnt == '0) && ((hz_cnt == '0) || !req_write);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      hz_cnt     <= '0;
      wake_cnt   <= '0;
      pd_q       <= 1'b0;
      ram_addr   <= '0;
      ram_cs_n   <= 1'b1;
      ram_cs     <= 1'b1;
      ram_we_n   <= 1'b1;
      ram_oe_n   <= 1'b1;
      ram_lb_n   <= 1'b1;
      ram_ub_n   <= 1'b1;
      ram_dq_out <= '0;
      ram_dq_oe  <= 1'b0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (hz_cnt != '0)   hz_cnt   <= hz_cnt - 1'b1;
      if (wake_cnt != '0) wake_cnt <= wake_cnt - 1'b1;
      case (st)
        S_IDLE: begin
          if (pwr_down) begin
            pd_q   <= 1'b1;
            ram_cs <= 1'b0;
          end else if (pd_q) begin
            pd_q     <= 1'b0;
            ram_cs   <= 1'b1;
            wake_cnt <= CW'(N_RC);
          end else if (req_valid && req_ready) begin
            ram_addr <= req_addr;
            ram_cs_n <= 1'b0;
            ram_lb_n <= ~req_mask[0];
            ram_ub_n <= ~req_mask[1];
            if (req_write) begin
              st         <= S_WR;
              cnt        <= CW'(N_WP - 1);
              ram_we_n   <= 1'b0;
              ram_dq_out <= req_wdata;
              ram_dq_oe  <= 1'b1;
            end else begin
              st       <= S_RD;
              cnt      <= CW'(N_RD - 1);
              ram_oe_n <= 1'b0;
            end
          end
        end
        S_RD: begin
          if (cnt == '0) begin
            rd_data  <= ram_dq_in & lane_bits;
            rd_valid <= 1'b1;
            ram_oe_n <= 1'b1;
            ram_cs_n <= 1'b1;
            ram_lb_n <= 1'b1;
            ram_ub_n <= 1'b1;
            hz_cnt   <= CW'(N_HZ);
            st       <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WR: begin
          if (cnt == '0) begin
            ram_we_n <= 1'b1;
            st       <= S_WH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          ram_dq_oe <= 1'b0;
          ram_cs_n  <= 1'b1;
          ram_lb_n  <= 1'b1;
          ram_ub_n  <= 1'b1;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  logic [CW-1:0] we_len, oe_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_len <= '0;
      oe_gap <= CW'(N_HZ + 1);
    end else begin
      if (ram_we_n)                    we_len <= '0;
      else if (we_len < CW'(N_WP))     we_len <= we_len + 1'b1;
      if (!ram_oe_n)                   oe_gap <= '0;
      else if (oe_gap < CW'(N_HZ + 1)) oe_gap <= oe_gap + 1'b1;
    end
  end

  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n || !ram_oe_n) |-> (!ram_cs_n && ram_cs));                     // R2
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);                                                 // R2
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_len >= CW'(N_WP)));                              // R4
  AST_WE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (ram_oe_n && ram_dq_oe));                                  // R4
  AST_WE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (ram_dq_oe && !ram_cs_n && $stable(ram_dq_out)));   // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && $past(!ram_cs_n)) |->
      ($stable(ram_addr) && $stable(ram_lb_n) && $stable(ram_ub_n)));        // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> ram_oe_n);                                                 // R7
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> (oe_gap > CW'(N_HZ)));                              // R7
  AST_PD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs |-> (ram_cs_n && ram_we_n && !req_ready));                       // R8

endmodule

// File: tb/sim_asram_ctl.sv
`timescale 1ns/1ps
module sim_asram_ctl;
  localparam int N_RD = 7, N_WP = 7, N_HZ = 3, N_RC = 7;
  localparam real HZ_NS = 20.0;

  logic clk = 1'b0, rst_n = 1'b0, pwr_down = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rd_valid, ram_cs_n, ram_cs, ram_we_n, ram_oe_n;
  logic ram_lb_n, ram_ub_n, ram_dq_oe;
  logic [15:0] rd_data, ram_dq_out, ram_dq_in;
  logic [17:0] ram_addr;

  int tests = 0, fails = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;

  asram_ctl u0 (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_cs(ram_cs),
    .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // memory model
  logic [15:0] mem [64];
  logic sel;
  assign sel = !ram_cs_n && ram_cs;
  assign ram_dq_in[15:8] = (sel && ram_we_n && !ram_oe_n && !ram_ub_n) ? mem[ram_addr[5:0]][15:8] : 8'hA5;
  assign ram_dq_in[7:0]  = (sel && ram_we_n && !ram_oe_n && !ram_lb_n) ? mem[ram_addr[5:0]][7:0]  : 8'h5A;

  always @(posedge ram_we_n) begin
    if (sel && ram_dq_oe) begin
      if (!ram_lb_n) mem[ram_addr[5:0]][7:0]  <= ram_dq_out[7:0];
      if (!ram_ub_n) mem[ram_addr[5:0]][15:8] <= ram_dq_out[15:8];
    end
  end

  realtime t_oe_rise = -1000.0;
  always @(posedge ram_oe_n) t_oe_rise = $realtime;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // behavioural reference
  int m_op = 0, m_age = 0, m_hz = 0, m_wake = 0;
  bit m_pdq = 0, m_rdv = 0;
  logic [17:0] m_addr = '0;
  logic [1:0]  m_mask = '0;
  logic [15:0] m_wd = '0, m_data = '0, m_rdata = '0;
  logic [15:0] shadow [64];

  function automatic bit m_ready();
    return (m_op == 0) && !pwr_down && !m_pdq && (m_wake == 0) && ((m_hz == 0) || !req_write);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_op = 0; m_age = 0; m_hz = 0; m_wake = 0; m_pdq = 0; m_rdv = 0;
    end else begin
      bit rdy;
      bit was_idle;
      rdy = m_ready();
      was_idle = (m_op == 0);
      m_rdv = 0;
      if (m_hz > 0) m_hz--;
      if (m_wake > 0) m_wake--;
      if (!was_idle) begin
        if (m_op == 1 && m_age == N_RD) begin
          m_op = 0; m_rdv = 1; m_rdata = m_data; m_hz = N_HZ;
        end else if (m_op == 2 && m_age == N_WP + 1) begin
          m_op = 0;
        end else begin
          m_age++;
        end
      end else if (pwr_down) begin
        m_pdq = 1;
      end else if (m_pdq) begin
        m_pdq = 0; m_wake = N_RC;
      end else if (req_valid && rdy) begin
        m_op = req_write ? 2 : 1; m_age = 1;
        m_addr = req_addr; m_mask = req_mask; m_wd = req_wdata;
        if (req_write) begin
          if (req_mask[0]) shadow[req_addr[5:0]][7:0]  = req_wdata[7:0];
          if (req_mask[1]) shadow[req_addr[5:0]][15:8] = req_wdata[15:8];
        end else begin
          m_data = shadow[req_addr[5:0]] & {{8{req_mask[1]}}, {8{req_mask[0]}}};
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      bit act;
      act = (m_op != 0);
      chk(ram_cs_n == !act, "R6", 32'(ram_cs_n), 32'(!act));
      chk(ram_cs == !m_pdq, "R8", 32'(ram_cs), 32'(!m_pdq));
      chk(ram_oe_n == !(m_op == 1), "R2", 32'(ram_oe_n), 32'(!(m_op == 1)));
      chk(ram_we_n == !(m_op == 2 && m_age <= N_WP), "R4", 32'(ram_we_n), 32'(!(m_op == 2 && m_age <= N_WP)));
      chk(ram_lb_n == !(act && m_mask[0]), "R3", 32'(ram_lb_n), 32'(!(act && m_mask[0])));
      chk(ram_ub_n == !(act && m_mask[1]), "R3", 32'(ram_ub_n), 32'(!(act && m_mask[1])));
      chk(ram_dq_oe == (m_op == 2), "R5", 32'(ram_dq_oe), 32'(m_op == 2));
      chk(req_ready == m_ready(), "R7/R8/R9 ready", 32'(req_ready), 32'(m_ready()));
      chk(rd_valid == m_rdv, "R2", 32'(rd_valid), 32'(m_rdv));
      if (m_rdv) chk(rd_data == m_rdata, "R3 data", 32'(rd_data), 32'(m_rdata));
      if (act) chk(ram_addr == m_addr, "R6 addr", 32'(ram_addr), 32'(m_addr));
      if (ram_dq_oe) begin
        chk(ram_dq_out == m_wd, "R4 data", 32'(ram_dq_out), 32'(m_wd));
        chk(ram_oe_n && ($realtime - t_oe_rise >= HZ_NS), "R7 turnaround",
            32'(int'($realtime - t_oe_rise)), 32'(int'(HZ_NS)));
      end
    end
  end

  task automatic do_op(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    forever begin
      bit acc;
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
      if (acc) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ram_cs_n && ram_cs && ram_we_n && ram_oe_n, "R1 strobes", {28'd0, ram_cs_n, ram_cs, ram_we_n, ram_oe_n}, 32'hF);
    chk(ram_lb_n && ram_ub_n && !ram_dq_oe, "R1 lanes", {29'd0, ram_lb_n, ram_ub_n, ram_dq_oe}, 32'h6);
    chk(req_ready, "R1 ready", 32'(req_ready), 32'd1);
    running = 1'b1;
    @(posedge clk); #1;

    do_op(1, 18'd1, 16'h1234, 2'b11);              // R4 full write
    do_op(0, 18'd1, 16'h0, 2'b11);                 // R2 read back
    do_op(1, 18'd2, 16'hBEEF, 2'b11);              // R7 write stalled behind read
    do_op(1, 18'd1, 16'hABCD, 2'b01);              // R3 lower lane only
    do_op(0, 18'd1, 16'h0, 2'b10);                 // R3 upper lane read
    do_op(0, 18'd1, 16'h0, 2'b01);                 // R3 lower lane read
    do_op(1, 18'd1, 16'hFFFF, 2'b00);              // R4 mask 00 no effect
    do_op(0, 18'd1, 16'h0, 2'b11);
    do_op(1, 18'h3FFC2, 16'h0F0F, 2'b10);          // R6 high address bits
    do_op(0, 18'h3FFC2, 16'h0, 2'b11);
    for (int i = 8; i < 14; i++) do_op(1, 18'(i), 16'(i * 16'h1111), 2'b11);
    for (int i = 8; i < 14; i++) do_op(0, 18'(i), 16'h0, 2'b11);   // R2 back-to-back reads
    idle(4);

    // R8/R9: power-down during a read with a write waiting
    do_op(0, 18'd9, 16'h0, 2'b11);
    idle(2);
    pwr_down = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'd20; req_wdata = 16'h7E57; req_mask = 2'b11;
    idle(20);
    pwr_down = 1'b0;
    do_op(1, 18'd20, 16'h7E57, 2'b11);
    do_op(0, 18'd20, 16'h0, 2'b11);
    // R8: power-down raised in idle together with a read request
    idle(5);
    pwr_down = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'd2; req_mask = 2'b11;
    idle(3);
    pwr_down = 1'b0;
    do_op(0, 18'd2, 16'h0, 2'b11);
    idle(20);
    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule